// File: doc/BRIEF.md
# Ring-Phase Gray-Code Time-to-Digital Encoder

This block is the digital back end of a time-to-digital converter whose code bits come from the phases of ring oscillators. A ring of delay stages is started on a start edge and frozen on a stop edge. The block reads the ring state and turns it straight into a reflected-binary Gray word using XOR groups of ring taps. It then decodes that word into a plain binary count. Ring stepping is modelled by a register ring that advances once per clock while a measurement runs. Each clock period therefore stands in for one delay stage.

Two tap sources can be chosen. The first is a single Johnson-style ring of 2^(W-1) stages, where every Gray bit is the XOR of a regular subset of taps. The second gives each Gray bit its own small ring with one tap. Only W capture flip-flops hold the result, where a flash converter of the same range would need 2^W. Because each ring step flips exactly one tap, the captured Gray word can never be a mixture of two distant codes. The binary decode can be a ripple XOR chain or a logarithmic fold.

Top module: `tdc_gray_encoder`

## Requirements
- R1: During and right after reset, `valid_o` is 0, `code_o` is 0 and `gray_o` is 0.
- R2: For a start rising edge seen at clock edge E0 and a stop rising edge seen at edge Ed (d >= 1) during the run, the reported `code_o` equals (d-1) mod 2^W, where W is the `GRAY_W` parameter.
- R3: `gray_o` is the reflected-binary Gray form of the count: gray = code XOR (code >> 1), with bit W-1 the most significant.
- R4: `gray_o` is loaded on the clock edge that sees the stop rising edge. `code_o` is updated and `valid_o` goes high on the next edge. `valid_o` is high for exactly one cycle.
- R5: The Gray words captured for elapsed counts n and n+1 differ in exactly one bit, including the step from 2^W-1 back to 0. Inside the ring, each advance changes exactly one tap.
- R6: Elapsed counts of 2^W or more wrap modulo 2^W without any invalid code.
- R7: A stop rising edge while no measurement runs is ignored: `valid_o` stays 0 and `code_o` and `gray_o` keep their values. A stop input held high does not re-trigger.
- R8: A start rising edge during a run, without a stop edge on the same clock edge, restarts the count from zero at that edge.
- R9: When the start and stop rising edges are seen on the same edge during a run, the capture happens and the start edge is ignored. A later stop edge then produces no result.
- R10: `code_o` holds its value between captures. The shared-ring and per-bit-ring tap sources, combined with either decoder, produce identical codes for the same elapsed count taken modulo the smaller range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period models one delay stage |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Measurement start; its rising edge clears and runs the ring |
| stop_i | input | 1 | Measurement stop; its rising edge captures the ring phase |
| gray_o | output | GRAY_W | Captured Gray word |
| code_o | output | GRAY_W | Decoded binary elapsed count |
| valid_o | output | 1 | One-cycle strobe marking a new `code_o` |

## Verification
The hardest condition to reach from the ports is the ring wrapping past its last state. This is the step from code 2^W-1 back to 0, where the most significant Gray bit falls and the XOR groups must all return to zero together. The stimulus reaches it with a sweep of every stop delay from 1 to 36 cycles. That sweep wraps the 4-bit instance twice and the 5-bit instance once. Between neighbouring delays the bench compares the Gray words for a single-bit difference and the binary codes for an increment of one. The same-edge start/stop case and the restart case are set up by placing both input edges on chosen falling-edge slots.

// File: rtl/tdcg_pkg.sv
package tdcg_pkg;

   // tap source variants
   localparam int SRC_SHARED_RING = 0;
   localparam int SRC_BIT_RINGS   = 1;

   // Gray decoder variants
   localparam int DEC_RIPPLE = 0;
   localparam int DEC_FOLD   = 1;

   // stages of the shared ring: 2^(w-1) stages give 2^w phases
   function automatic int shared_ring_len(input int w);
      return 1 << (w - 1);
   endfunction

   // stages of the private ring behind Gray bit k
   function automatic int bit_ring_len(input int w, input int k);
      return (k == w - 1) ? (1 << (w - 1)) : (1 << (k + 1));
   endfunction

   // tap index that carries Gray bit k (same rule for both sources)
   function automatic int bit_tap(input int k);
      return (1 << k) - 1;
   endfunction

   typedef struct packed {
      logic adv;   // ring steps one stage
      logic clr;   // ring returns to phase zero and runs
      logic cap;   // phase is captured, run ends
   } tdcg_ctl_t;

endpackage

// File: rtl/tdcg_edge_ctl.sv
module tdcg_edge_ctl
   import tdcg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      stop_i,
   output tdcg_ctl_t ctl_o
);

   logic start_d, stop_d, run_q;
   logic start_rise, stop_rise;

   assign start_rise = start_i & ~start_d;
   assign stop_rise  = stop_i  & ~stop_d;

   // capture wins over a simultaneous restart
   assign ctl_o.cap = stop_rise & run_q;
   assign ctl_o.clr = start_rise & ~ctl_o.cap;
   assign ctl_o.adv = run_q & ~ctl_o.cap & ~ctl_o.clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_d <= 1'b0;
         stop_d  <= 1'b0;
         run_q   <= 1'b0;
      end else begin
         start_d <= start_i;
         stop_d  <= stop_i;
         if (ctl_o.cap)
            run_q <= 1'b0;
         else if (ctl_o.clr)
            run_q <= 1'b1;
      end
   end

   p_capture_ends_run_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o.cap |=> !run_q);

   p_restart_runs_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o.clr |=> run_q);

   p_idle_stop_ignored_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !ctl_o.cap);

endmodule

// File: rtl/tdcg_ring_bank.sv
module tdcg_ring_bank
   import tdcg_pkg::*;
#(
   parameter int GRAY_W  = 4,
   parameter int TAP_SRC = SRC_SHARED_RING
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic              clr_i,
   output logic [GRAY_W-1:0] gray_raw_o
);

   if (TAP_SRC == SRC_SHARED_RING) begin : g_shared
      localparam int L = shared_ring_len(GRAY_W);
      logic [L-1:0] taps_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clr_i)
            taps_q <= '0;
         else if (adv_i)
            taps_q <= {taps_q[L-2:0], ~taps_q[L-1]};
      end

      // Gray bit k: XOR of taps whose index is 2^k-1 modulo 2^(k+1)
      always_comb begin
         gray_raw_o = '0;
         for (int k = 0; k < GRAY_W; k++)
            for (int i = 0; i < L; i++)
               if ((i % (1 << (k + 1))) == bit_tap(k))
                  gray_raw_o[k] = gray_raw_o[k] ^ taps_q[i];
      end

      p_single_tap_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
         adv_i |=> ($countones(taps_q ^ $past(taps_q)) == 1));

   end else begin : g_per_bit
      for (genvar k = 0; k < GRAY_W; k++) begin : g_ring
         localparam int M   = bit_ring_len(GRAY_W, k);
         localparam int TAP = bit_tap(k);
         logic [M-1:0] ring_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr_i)
               ring_q <= '0;
            else if (adv_i)
               ring_q <= {ring_q[M-2:0], ~ring_q[M-1]};
         end

         assign gray_raw_o[k] = ring_q[TAP];
      end
   end

   p_gray_unit_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> ($countones(gray_raw_o ^ $past(gray_raw_o)) == 1));

   p_gray_frozen_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !clr_i) |=> $stable(gray_raw_o));

   p_restart_phase_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (gray_raw_o == '0));

endmodule

// File: rtl/tdcg_gray_dec.sv
module tdcg_gray_dec
   import tdcg_pkg::*;
#(
   parameter int GRAY_W    = 4,
   parameter int DEC_STYLE = DEC_RIPPLE
) (
   input  logic [GRAY_W-1:0] gray_i,
   output logic [GRAY_W-1:0] bin_o
);

   if (DEC_STYLE == DEC_RIPPLE) begin : g_ripple
      // binary bit = XOR of all Gray bits at or above it
      always_comb begin
         logic acc;
         acc = 1'b0;
         for (int i = GRAY_W - 1; i >= 0; i--) begin
            acc      = acc ^ gray_i[i];
            bin_o[i] = acc;
         end
      end
   end else begin : g_fold
      localparam int NST = $clog2(GRAY_W);
      logic [GRAY_W-1:0] st [NST+1];
      assign st[0] = gray_i;
      for (genvar j = 0; j < NST; j++) begin : g_stage
         assign st[j+1] = st[j] ^ (st[j] >> (1 << j));
      end
      assign bin_o = st[NST];
   end

endmodule

// File: rtl/tdc_gray_encoder.sv
module tdc_gray_encoder
   import tdcg_pkg::*;
#(
   parameter int GRAY_W    = 4,
   parameter int TAP_SRC   = SRC_SHARED_RING,
   parameter int DEC_STYLE = DEC_RIPPLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   output logic [GRAY_W-1:0] gray_o,
   output logic [GRAY_W-1:0] code_o,
   output logic              valid_o
);

   if (GRAY_W < 2 || GRAY_W > 8) begin : g_bad_width
      $error("tdc_gray_encoder: GRAY_W must lie in 2..8");
   end
   if (TAP_SRC != SRC_SHARED_RING && TAP_SRC != SRC_BIT_RINGS) begin : g_bad_src
      $error("tdc_gray_encoder: unknown TAP_SRC");
   end
   if (DEC_STYLE != DEC_RIPPLE && DEC_STYLE != DEC_FOLD) begin : g_bad_dec
      $error("tdc_gray_encoder: unknown DEC_STYLE");
   end

   tdcg_ctl_t         ctl;
   logic [GRAY_W-1:0] gray_raw, gray_q, code_q, bin;
   logic              cap_q, valid_q;

   tdcg_edge_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .stop_i  (stop_i),
      .ctl_o   (ctl)
   );

   tdcg_ring_bank #(.GRAY_W(GRAY_W), .TAP_SRC(TAP_SRC)) u_rings (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_i      (ctl.adv),
      .clr_i      (ctl.clr),
      .gray_raw_o (gray_raw)
   );

   tdcg_gray_dec #(.GRAY_W(GRAY_W), .DEC_STYLE(DEC_STYLE)) u_dec (
      .gray_i (gray_q),
      .bin_o  (bin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gray_q  <= '0;
         code_q  <= '0;
         cap_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         cap_q   <= ctl.cap;
         valid_q <= cap_q;
         if (ctl.cap)
            gray_q <= gray_raw;
         if (cap_q)
            code_q <= bin;
      end
   end

   assign gray_o  = gray_q;
   assign code_o  = code_q;
   assign valid_o = valid_q;

   p_valid_after_capture_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ctl.cap |=> ##1 valid_o);

   p_valid_one_cycle_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   p_code_holds_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(code_o));

   p_code_gray_pair_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ((code_o ^ (code_o >> 1)) == gray_o));

   p_gray_only_on_capture_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.cap |=> $stable(gray_o));

endmodule

// File: tb/tdc_gray_encoder_test.sv
`timescale 1ns/1ps
module tdc_gray_encoder_test;
   import tdcg_pkg::*;

   logic clk = 1'b0;
   logic rst_n, start, stop;
   logic [3:0] g4, c4;
   logic [4:0] g5, c5;
   logic       v4, v5;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   tdc_gray_encoder #(.GRAY_W(4), .TAP_SRC(SRC_SHARED_RING), .DEC_STYLE(DEC_RIPPLE)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
      .gray_o(g4), .code_o(c4), .valid_o(v4));

   tdc_gray_encoder #(.GRAY_W(5), .TAP_SRC(SRC_BIT_RINGS), .DEC_STYLE(DEC_FOLD)) uut_alt (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
      .gray_o(g5), .code_o(c5), .valid_o(v5));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int to_gray(input int b);
      return b ^ (b >> 1);
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // capture check: stop edge seen at current negedge slot, expected count e
   task automatic expect_capture(input int e);
      int e4, e5;
      e4 = e % 16;
      e5 = e % 32;
      @(negedge clk);
      chk(v4 == 1'b0, "R4 valid low on capture edge (w4)", v4, 0);
      chk(v5 == 1'b0, "R4 valid low on capture edge (w5)", v5, 0);
      chk(g4 == to_gray(e4), "R3 gray word (w4)", g4, to_gray(e4));
      chk(g5 == to_gray(e5), "R3 gray word (w5)", g5, to_gray(e5));
      @(negedge clk);
      chk(v4 == 1'b1, "R4 valid one edge later (w4)", v4, 1);
      chk(v5 == 1'b1, "R4 valid one edge later (w5)", v5, 1);
      chk(c4 == e4, (e >= 16) ? "R6 wrapped code (w4)" : "R2 code (w4)", c4, e4);
      chk(c5 == e5, (e >= 32) ? "R6 wrapped code (w5)" : "R2 code (w5)", c5, e5);
      chk(c4 == (c5 % 16), "R10 variants agree", c4, c5 % 16);
   endtask

   task automatic measure(input int d);
      @(negedge clk);
      start = 1'b1;
      for (int i = 1; i <= d; i++) begin
         @(negedge clk);
         if (i == 1) start = 1'b0;
      end
      stop = 1'b1;
      expect_capture(d - 1);
      stop = 1'b0;
      @(negedge clk);
      chk(v4 == 1'b0, "R4 valid pulse ends (w4)", v4, 0);
      chk(v5 == 1'b0, "R4 valid pulse ends (w5)", v5, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      logic [3:0] pg4, pc4;
      logic [4:0] pg5, pc5;
      rst_n = 1'b0;
      start = 1'b0;
      stop  = 1'b0;
      repeat (3) @(negedge clk);
      chk(v4 == 1'b0 && v5 == 1'b0, "R1 valid in reset", v4 | v5, 0);
      chk(c4 == 0 && c5 == 0, "R1 code in reset", c4 + c5, 0);
      chk(g4 == 0 && g5 == 0, "R1 gray in reset", g4 + g5, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(v4 == 1'b0 && c4 == 0 && g4 == 0, "R1 state after reset", c4, 0);

      // sweep every delay, wrapping both instances
      pg4 = '0; pc4 = '0; pg5 = '0; pc5 = '0;
      for (int d = 1; d <= 36; d++) begin
         measure(d);
         if (d > 1) begin
            chk($countones(g4 ^ pg4) == 1, "R5 one-bit gray step (w4)", $countones(g4 ^ pg4), 1);
            chk($countones(g5 ^ pg5) == 1, "R5 one-bit gray step (w5)", $countones(g5 ^ pg5), 1);
            chk(c4 == 4'(pc4 + 1), "R5 code counts up (w4)", c4, 4'(pc4 + 1));
            chk(c5 == 5'(pc5 + 1), "R5 code counts up (w5)", c5, 5'(pc5 + 1));
         end
         pg4 = g4; pc4 = c4; pg5 = g5; pc5 = c5;
      end

      // R10: code holds while idle
      repeat (4) @(negedge clk);
      chk(c4 == pc4 && c5 == pc5, "R10 code holds idle", c4, pc4);

      // R7: stop edge while idle, then held high
      stop = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(v4 == 1'b0 && v5 == 1'b0, "R7 idle stop gives no valid", v4 | v5, 0);
         chk(c4 == pc4 && g4 == pg4, "R7 idle stop leaves code and gray", c4, pc4);
         chk(c5 == pc5 && g5 == pg5, "R7 idle stop leaves wide code", c5, pc5);
      end
      stop = 1'b0;
      @(negedge clk);

      // R8: restart during a run
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (2) @(negedge clk);
      stop = 1'b1;
      expect_capture(2);
      chk(c4 == 2, "R8 restart counts from zero", c4, 2);
      stop = 1'b0;
      repeat (2) @(negedge clk);

      // R9: start and stop edges on the same clock edge
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (6) @(negedge clk);
      stop  = 1'b1;
      start = 1'b1;
      expect_capture(6);
      stop = 1'b0;
      repeat (2) @(negedge clk);
      stop = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(v4 == 1'b0 && v5 == 1'b0, "R9 ignored start leaves no run", v4 | v5, 0);
         chk(c4 == 6 && c5 == 6, "R9 code kept", c4, 6);
      end
      stop  = 1'b0;
      start = 1'b0;
      repeat (2) @(negedge clk);

      finish_run();
   end

endmodule